// File: doc/BRIEF.md
# Blanking-Synchronized I2C Control Register Bank

This block is a write-only I2C slave that fills a bank of 8-bit control registers. A transfer carries the device address, then a subaddress byte, then one or more data bytes. Bit 7 of the subaddress selects how the write lands. With bit 7 clear (immediate path), the addressed register takes the value once the transfer is closed by a STOP. With bit 7 set (deferred path), the value is parked in a single staging buffer. It moves into its register on the next rising edge of the vertical-blanking input, so a geometry change never shows mid-picture. After one deferred write, the slave refuses to acknowledge anything until the next blanking pulse.

Acknowledge also depends on two inputs. While the supply-good input is low, the slave acknowledges nothing. While the standby input is high, the deferred path is disabled. SCL and SDA are sampled through two-flop synchronizers, and START and STOP are recognized from SDA edges while SCL is high. The open-drain SDA line is modelled as an input plus an active-high pull-down enable.

The controller is one state machine with these states: `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_SUB`, `ST_SUB_ACK`, `ST_DATA`, `ST_DATA_ACK`, `ST_SKIP`. Its transitions are as follows:
- A START moves any state to `ST_ADDR`. A STOP moves any state to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` when the address matches, supply is good and no lockout is set. Otherwise it goes to `ST_SKIP`.
- `ST_ADDR_ACK` goes to `ST_SUB`.
- `ST_SUB` goes to `ST_SUB_ACK` when supply is good and the byte is not a deferred subaddress during standby. Otherwise it goes to `ST_SKIP`.
- `ST_SUB_ACK` goes to `ST_DATA`.
- `ST_DATA` goes to `ST_DATA_ACK` when supply is good. Otherwise it goes to `ST_SKIP`.
- `ST_DATA_ACK` returns to `ST_DATA` for any further byte.
- `ST_SKIP` holds until the next START or STOP.

A byte state leaves on the SCL falling edge that follows its eighth bit. An acknowledge state leaves on the SCL falling edge that ends the ninth clock.

Top module: `blanksync_i2c_regs`

## Requirements
- R1: Only the address byte 0x8C (7-bit address 0x46 with the write bit, sent MSB first) is acknowledged. Any other address byte gets no acknowledge, and the transfer that follows it changes no register.
- R2: With subaddress bit 7 = 0, the register indexed by subaddress bits 6:0 holds the last data byte a few cycles after the STOP that closes the transfer.
- R3: Several data bytes after one subaddress all target the same register, and the last one is kept. The neighbouring register is untouched.
- R4: With subaddress bit 7 = 1, the register keeps its old value after the STOP. It takes the buffered byte only after the next rising edge of `vblank`.
- R5: After a deferred transfer closed by a STOP, every address byte is not acknowledged until the next `vblank` rising edge. Afterwards, transfers are acknowledged again.
- R6: While `standby` = 1, a subaddress with bit 7 = 1 is not acknowledged, and data sent after it is discarded, even across a later `vblank`.
- R7: While `supply_ok` = 0, no byte is acknowledged and no register changes.
- R8: A subaddress index of 32 or above (beyond NREG) is acknowledged, but no register changes.
- R9: A repeated START restarts the address phase. A transfer not ended by a STOP writes nothing and sets no lockout.
- R10: After reset, every register reads 0 and `sda_oe` is 0. Immediate writes have no per-frame limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | Pulls SDA low when 1 (acknowledge) |
| supply_ok | input | 1 | Supply good; acknowledge only while high |
| standby | input | 1 | Disables the deferred write path |
| vblank | input | 1 | Vertical-blanking pulse; rising edge commits the buffer |
| regs_o | output | NREG*8 | Register bank, register i at bits i*8+7:i*8 |

## Verification
The assertions check four behaviours on every cycle:
- Any acknowledge pull-down starts only after a cycle with good supply.
- No address acknowledge happens while the lockout is set.
- No subaddress acknowledge follows a deferred subaddress seen during standby.
- The register bus changes only right after a STOP or a blanking edge.

Only the bench's scenarios can show end-to-end effects. These include the hold of a deferred value until blanking, the last-byte-wins rule for multi-byte writes, out-of-range indices leaving the bank intact, and a repeated START discarding the open transfer without locking out the next one.

// File: rtl/blanksync_pkg.sv
package blanksync_pkg;
    localparam logic [7:0] DEV_WR_ADDR = 8'h8C;
    localparam int         BITS_PER_BYTE = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } bus_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // three stages: two for metastability, one as the previous value
    logic [2:0] scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 3'b111;
            sda_p <= 3'b111;
        end else begin
            scl_p <= {scl_p[1:0], scl_i};
            sda_p <= {sda_p[1:0], sda_i};
        end
    end

    assign sda_s     = sda_p[1];
    assign scl_rise  = scl_p[1] & ~scl_p[2];
    assign scl_fall  = ~scl_p[1] & scl_p[2];
    assign start_det = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
    assign stop_det  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
    import blanksync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       supply_ok,
    input  logic       standby,
    input  logic       lock,
    output logic       sda_oe,
    output logic       wr_stb,
    output logic       wr_buf,
    output logic [6:0] wr_idx,
    output logic [7:0] wr_data,
    output bus_state_t state,
    output logic [7:0] byte_q
);
    localparam logic [3:0] FULL = 4'(BITS_PER_BYTE);

    bus_state_t state_q, state_d;
    logic [3:0] cnt_q;
    logic [7:0] sh_q, sub_q, pdata_q;
    logic       pend_q;
    logic       byte_done, addr_ok, sub_ok, shifting;

    assign byte_done = scl_fall && (cnt_q == FULL);
    assign addr_ok   = (sh_q == DEV_WR_ADDR) && supply_ok && !lock;
    assign sub_ok    = supply_ok && !(sh_q[7] && standby);
    assign shifting  = (state_q == ST_ADDR) || (state_q == ST_SUB) || (state_q == ST_DATA);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SKIP: state_d = state_q;
                ST_ADDR:     if (byte_done) state_d = addr_ok ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall)  state_d = ST_SUB;
                ST_SUB:      if (byte_done) state_d = sub_ok ? ST_SUB_ACK : ST_SKIP;
                ST_SUB_ACK:  if (scl_fall)  state_d = ST_DATA;
                ST_DATA:     if (byte_done) state_d = supply_ok ? ST_DATA_ACK : ST_SKIP;
                ST_DATA_ACK: if (scl_fall)  state_d = ST_DATA;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            sh_q    <= '0;
            sub_q   <= '0;
            pdata_q <= '0;
            pend_q  <= 1'b0;
        end else if (start_det || stop_det) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (shifting && scl_rise && cnt_q != FULL) begin
                sh_q  <= {sh_q[6:0], sda_s};
                cnt_q <= cnt_q + 4'd1;
            end
            if (state_q != state_d) cnt_q <= '0;
            if (state_q == ST_SUB && state_d == ST_SUB_ACK) sub_q <= sh_q;
            if (state_q == ST_DATA && state_d == ST_DATA_ACK) begin
                pdata_q <= sh_q;
                pend_q  <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe  = (state_q == ST_ADDR_ACK) || (state_q == ST_SUB_ACK) || (state_q == ST_DATA_ACK);
        wr_stb  = stop_det && pend_q;
        wr_buf  = sub_q[7];
        wr_idx  = sub_q[6:0];
        wr_data = pdata_q;
        state   = state_q;
        byte_q  = sh_q;
    end
endmodule

// File: rtl/reg_commit.sv
module reg_commit #(
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stb,
    input  logic            wr_buf,
    input  logic [6:0]      wr_idx,
    input  logic [7:0]      wr_data,
    input  logic            vblank,
    output logic            lock,
    output logic            vb_rise,
    output logic [NREG*8-1:0] regs_o
);
    logic       vb_q, buf_valid;
    logic [6:0] buf_idx;
    logic [7:0] buf_data;

    assign vb_rise = vblank & ~vb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vb_q      <= 1'b0;
            buf_valid <= 1'b0;
            lock      <= 1'b0;
            buf_idx   <= '0;
            buf_data  <= '0;
        end else begin
            vb_q <= vblank;
            if (vb_rise) begin
                buf_valid <= 1'b0;
                lock      <= 1'b0;
            end
            if (wr_stb && wr_buf) begin
                buf_idx   <= wr_idx;
                buf_data  <= wr_data;
                buf_valid <= 1'b1;
                lock      <= 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_o[i*8 +: 8] <= '0;
            else if (wr_stb && !wr_buf && wr_idx == 7'(i))
                regs_o[i*8 +: 8] <= wr_data;
            else if (vb_rise && buf_valid && buf_idx == 7'(i))
                regs_o[i*8 +: 8] <= buf_data;
        end
    end
endmodule

// File: rtl/blanksync_i2c_regs.sv
module blanksync_i2c_regs
    import blanksync_pkg::*;
#(
    parameter int NREG = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              supply_ok,
    input  logic              standby,
    input  logic              vblank,
    output logic [NREG*8-1:0] regs_o
);
    initial begin
        if (NREG < 1 || NREG > 128) $error("NREG out of range");
    end

    logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_stb, wr_buf, lock, vb_rise;
    logic [6:0] wr_idx;
    logic [7:0] wr_data, byte_q;
    bus_state_t state;

    i2c_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_wr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .supply_ok(supply_ok), .standby(standby), .lock(lock),
        .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_buf(wr_buf),
        .wr_idx(wr_idx), .wr_data(wr_data), .state(state), .byte_q(byte_q)
    );

    reg_commit #(.NREG(NREG)) u_commit (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_buf(wr_buf),
        .wr_idx(wr_idx), .wr_data(wr_data), .vblank(vblank),
        .lock(lock), .vb_rise(vb_rise), .regs_o(regs_o)
    );
endmodule

// File: rtl/blanksync_chk.sv
module blanksync_chk
    import blanksync_pkg::*;
#(
    parameter int NREG = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              supply_ok,
    input logic              standby,
    input logic              lock,
    input logic              stop_det,
    input logic              vb_rise,
    input bus_state_t        state,
    input logic [7:0]        byte_q,
    input logic [NREG*8-1:0] regs_o
);
    // R7
    ack_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(supply_ok));

    // R5
    no_addr_ack_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> !lock);

    // R6
    no_deferred_in_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && state == ST_SUB_ACK) |-> !$past(standby && byte_q[7]));

    // R2
    regs_change_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> $past(stop_det || vb_rise));
endmodule

bind blanksync_i2c_regs blanksync_chk #(.NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .supply_ok(supply_ok),
    .standby(standby), .lock(lock), .stop_det(stop_det), .vb_rise(vb_rise),
    .state(state), .byte_q(byte_q), .regs_o(regs_o)
);

// File: tb/blanksync_i2c_regs_test.sv
module blanksync_i2c_regs_test;
    localparam int NREG = 32;
    localparam int Q    = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic supply_ok = 1'b1, standby = 1'b0, vblank = 1'b0;
    logic sda_oe;
    logic [NREG*8-1:0] regs_o;
    logic sda_line;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;
    logic [7:0] exp_r [NREG];

    assign sda_line = sda_m & ~sda_oe;
    always #5 clk = ~clk;

    blanksync_i2c_regs #(.NREG(NREG)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .supply_ok(supply_ok), .standby(standby),
        .vblank(vblank), .regs_o(regs_o)
    );

    function automatic logic [7:0] get_reg(input int i);
        return regs_o[i*8 +: 8];
    endfunction

    function automatic int bank_mismatches();
        int m = 0;
        for (int i = 0; i < NREG; i++) if (get_reg(i) !== exp_r[i]) m++;
        return m;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_reg(input int i, input string req);
        chk(get_reg(i) === exp_r[i], req, get_reg(i), exp_r[i]);
    endtask

    task automatic chk_bank(input string req);
        int m;
        m = bank_mismatches();
        chk(m == 0, req, m, 0);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int k = 7; k >= 0; k--) begin
            sda_m = b[k]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic xfer(input logic [7:0] a, input logic [7:0] s,
                        input logic [7:0] d0, input logic [7:0] d1, input int nd,
                        input bit do_stop, output bit aa, output bit as, output bit ad);
        i2c_start();
        send_byte(a, aa);
        send_byte(s, as);
        send_byte(d0, ad);
        if (nd > 1) send_byte(d1, ad);
        if (do_stop) i2c_stop();
        tick(4);
    endtask

    task automatic vb_pulse();
        vblank = 1'b1; tick(3);
        vblank = 1'b0; tick(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit aa, as, ad;
        void'($urandom(32'd2024));
        for (int i = 0; i < NREG; i++) exp_r[i] = 8'h00;
        tick(4);
        rst_n = 1'b1;
        tick(4);

        // R10 reset state
        chk_bank("R10 reset bank");
        chk(sda_oe == 1'b0, "R10 sda released", sda_oe, 0);

        // R2 direct write
        xfer(8'h8C, 8'h03, 8'hA5, 8'h00, 1, 1, aa, as, ad);
        exp_r[3] = 8'hA5;
        chk(aa && as && ad, "R2 acks", {aa, as, ad}, 3'b111);
        chk_reg(3, "R2 direct value");

        // R1 wrong address
        xfer(8'h8E, 8'h04, 8'h11, 8'h00, 1, 1, aa, as, ad);
        chk(!aa, "R1 wrong addr nack", aa, 0);
        chk_bank("R1 no change");

        // R3 multi-byte, no auto-increment
        xfer(8'h8C, 8'h07, 8'h21, 8'h42, 2, 1, aa, as, ad);
        exp_r[7] = 8'h42;
        chk_reg(7, "R3 last byte kept");
        chk_reg(8, "R3 neighbour untouched");

        // R4 buffered write waits for blanking
        xfer(8'h8C, 8'h85, 8'h5A, 8'h00, 1, 1, aa, as, ad);
        chk(aa && as && ad, "R4 buffered acks", {aa, as, ad}, 3'b111);
        chk_reg(5, "R4 held before vblank");

        // R5 lockout
        xfer(8'h8C, 8'h06, 8'h66, 8'h00, 1, 1, aa, as, ad);
        chk(!aa, "R5 locked addr nack", aa, 0);
        chk_reg(6, "R5 locked no write");
        vb_pulse();
        exp_r[5] = 8'h5A;
        chk_reg(5, "R4 committed on vblank");
        xfer(8'h8C, 8'h06, 8'h66, 8'h00, 1, 1, aa, as, ad);
        exp_r[6] = 8'h66;
        chk(aa, "R5 accepted after vblank", aa, 1);
        chk_reg(6, "R5 write after vblank");

        // R6 standby blocks deferred path
        standby = 1'b1;
        xfer(8'h8C, 8'h8A, 8'hC3, 8'h00, 1, 1, aa, as, ad);
        chk(aa && !as, "R6 sub nack in standby", {aa, as}, 2'b10);
        vb_pulse();
        chk_reg(10, "R6 data discarded");
        xfer(8'h8C, 8'h0A, 8'h3C, 8'h00, 1, 1, aa, as, ad);
        exp_r[10] = 8'h3C;
        chk_reg(10, "R6 direct still works in standby");
        standby = 1'b0;

        // R7 supply low
        supply_ok = 1'b0;
        xfer(8'h8C, 8'h0B, 8'h99, 8'h00, 1, 1, aa, as, ad);
        chk(!aa && !as && !ad, "R7 no ack", {aa, as, ad}, 0);
        chk_bank("R7 no change");
        supply_ok = 1'b1;

        // R8 out-of-range index
        xfer(8'h8C, 8'h25, 8'hEE, 8'h00, 1, 1, aa, as, ad);
        chk(aa && as && ad, "R8 acked", {aa, as, ad}, 3'b111);
        chk_bank("R8 bank intact");

        // R9 repeated START discards the open deferred write, no lockout
        xfer(8'h8C, 8'h8C, 8'h77, 8'h00, 1, 0, aa, as, ad);
        xfer(8'h8C, 8'h0D, 8'h12, 8'h00, 1, 1, aa, as, ad);
        exp_r[13] = 8'h12;
        chk_reg(13, "R9 restarted transfer written");
        vb_pulse();
        chk_reg(12, "R9 unclosed deferred dropped");
        xfer(8'h8C, 8'h0E, 8'h34, 8'h00, 1, 1, aa, as, ad);
        exp_r[14] = 8'h34;
        chk(aa, "R9 no lockout", aa, 1);

        // R10 random direct writes, many per frame
        for (int it = 0; it < 30; it++) begin
            int idx;
            logic [7:0] d;
            idx = int'($urandom_range(0, NREG - 1));
            d = 8'($urandom);
            xfer(8'h8C, {1'b0, 7'(idx)}, d, 8'h00, 1, 1, aa, as, ad);
            exp_r[idx] = d;
            chk(aa && as && ad && get_reg(idx) === d, "R10 random direct", get_reg(idx), d);
        end
        chk_bank("R10 bank after random");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule